// File: doc/BRIEF.md
# Dual Down-Counter Pulse-Width Generator

This block makes a pulse-width modulated level from two down-counting timers. The first timer counts out the period and the second counts out the high time. Each timer is loaded with its cycle count minus two. Both timers are armed only when every timer is configured the same way: count direction down, automatic reload on, capture off and waveform output on. With the block armed, a one-cycle start request loads both counters from their load inputs in the same clock. From that edge on the output is high.

The output rises again each time the period timer wraps and reloads. It falls when the high-time timer wraps. Each period wrap also reloads the high-time timer, so the two counters stay aligned from one period to the next. If the high time is as long as the period or longer, the set wins and the output never falls. Dropping the enable stops both counters where they are and forces the output low. The load values and mode bits are kept, so a new start request resumes with the same settings.

All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `pwm_dual_timer`

## Requirements
- R1: While reset is asserted and after it is released, `pwm_out` is 0 and `cnt_period` is 0 until a start is accepted.
- R2: With the block armed (R7), `start_all` high at an edge loads `cnt_period` with `period_load` and drives `pwm_out` high after that edge.
- R3: Once started, the output rises every `period_load + 2` cycles, and `cnt_period` steps down by one per cycle from `period_load` to 0.
- R4: When `high_load < period_load`, each period has exactly `high_load + 2` high cycles, including the case `high_load = 0`.
- R5: When `high_load >= period_load`, `pwm_out` stays high for as long as the block runs.
- R6: With `pwm_en` low at an edge, `pwm_out` is 0 after that edge and `cnt_period` holds its value.
- R7: The block is armed only when `pwm_en` is 1 and, for both timers (bit 0 = period timer, bit 1 = high-time timer), `mode_down`=1, `mode_reload`=1, `mode_capture`=0 and `mode_gen`=1. Otherwise the output is low and `start_all` has no effect.
- R8: After a disable, raising `pwm_en` and pulsing `start_all` restarts the same waveform from the retained load values.
- R9: A load value changed while running takes effect at the next period boundary. The period in progress is not altered.
- R10: `start_all` while `pwm_en` is 0 does not start the timers. The output stays low and `cnt_period` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_en | input | 1 | Waveform enable; low stops both timers and forces the output low |
| start_all | input | 1 | Loads and starts both timers in the same cycle |
| period_load | input | CW | Period count minus two |
| high_load | input | CW | High-time count minus two |
| mode_down | input | 2 | Per-timer down-count select |
| mode_reload | input | 2 | Per-timer automatic reload select |
| mode_capture | input | 2 | Per-timer capture select (must be 0) |
| mode_gen | input | 2 | Per-timer waveform output enable |
| cnt_period | output | CW | Current value of the period timer |
| cnt_high | output | CW | Current value of the high-time timer |
| pwm_out | output | 1 | Waveform output |

## Verification
The checker relies on the mode bits and loads being driven from registers. They must be stable across each clock edge, and `start_all` is expected to be a single-cycle request. The stimulus changes every input on the falling clock edge only. Loads are altered either while the block is stopped or in mid-period, to reach R9. Mode bits are broken one at a time, and each is restored before the next run. The rising-edge property assumes a rise can only follow a start or a period wrap, and no stimulus forces the output any other way.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  typedef struct packed {
    logic dn;
    logic arl;
    logic cap;
    logic gen;
  } tmr_mode_t;

  // A timer may take part in the waveform only in this exact mode
  function automatic logic mode_fits_pwm(tmr_mode_t m);
    return m.dn & m.arl & ~m.cap & m.gen;
  endfunction
endpackage

// File: rtl/pwm_dt_timer.sv
module pwm_dt_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop,
  input  logic          start,
  input  logic          resync,
  input  logic [CW-1:0] load,
  output logic [CW-1:0] count,
  output logic          wrap
);
  logic run_q;

  // Count load..0, spend one wrap cycle, then reload: load+2 cycles per lap
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      wrap  <= 1'b0;
      run_q <= 1'b0;
    end else if (stop) begin
      run_q <= 1'b0;
      wrap  <= 1'b0;
    end else if (start) begin
      count <= load;
      wrap  <= 1'b0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (resync || wrap) begin
        count <= load;
        wrap  <= 1'b0;
      end else if (count == '0) begin
        wrap <= 1'b1;
      end else begin
        count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_dt_level.sv
module pwm_dt_level (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic set_go,
  input  logic set_lap,
  input  logic clr_hi,
  output logic q
);
  // Set beats clear so a high time >= period never drops the level
  always_ff @(posedge clk) begin
    if (!rst_n)                q <= 1'b0;
    else if (kill)             q <= 1'b0;
    else if (set_go || set_lap) q <= 1'b1;
    else if (clr_hi)           q <= 1'b0;
  end
endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
  import pwm_dt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_en,
  input  logic          start_all,
  input  logic [CW-1:0] period_load,
  input  logic [CW-1:0] high_load,
  input  logic [1:0]    mode_down,
  input  logic [1:0]    mode_reload,
  input  logic [1:0]    mode_capture,
  input  logic [1:0]    mode_gen,
  output logic [CW-1:0] cnt_period,
  output logic [CW-1:0] cnt_high,
  output logic          pwm_out
);
  localparam int NT = 2;

  tmr_mode_t     mode [NT];
  logic [NT-1:0] fits;
  logic [NT-1:0] wrap;
  logic [CW-1:0] ld   [NT];
  logic [CW-1:0] cnt  [NT];
  logic          armed, go, halt;

  assign ld[0] = period_load;
  assign ld[1] = high_load;

  assign armed = pwm_en & (&fits);
  assign halt  = ~armed;
  assign go    = armed & start_all;

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    assign mode[g] = '{dn: mode_down[g], arl: mode_reload[g],
                       cap: mode_capture[g], gen: mode_gen[g]};
    assign fits[g] = mode_fits_pwm(mode[g]);

    // The high-time timer restarts on every period wrap
    pwm_dt_timer #(.CW(CW)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .stop   (halt),
      .start  (go),
      .resync ((g == 0) ? 1'b0 : wrap[0]),
      .load   (ld[g]),
      .count  (cnt[g]),
      .wrap   (wrap[g])
    );
  end

  pwm_dt_level u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .kill    (halt),
    .set_go  (go),
    .set_lap (wrap[0]),
    .clr_hi  (wrap[1]),
    .q       (pwm_out)
  );

  assign cnt_period = cnt[0];
  assign cnt_high   = cnt[1];
endmodule

// File: rtl/pwm_dual_timer_chk.sv
module pwm_dual_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwm_en,
  input logic          start_all,
  input logic [1:0]    mode_down,
  input logic [1:0]    mode_reload,
  input logic [1:0]    mode_capture,
  input logic [1:0]    mode_gen,
  input logic [CW-1:0] cnt_period,
  input logic          pwm_out
);
  logic cfg_ok;
  assign cfg_ok = (&mode_down) & (&mode_reload) & ~(|mode_capture) & (&mode_gen);

  // R2
  start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_all && pwm_en && cfg_ok) |=> pwm_out);

  // R6
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> !pwm_out);

  // R6
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> $stable(cnt_period));

  // R7
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && !cfg_ok) |=> !pwm_out);

  // R3
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> ($past(start_all) || ($past(cnt_period) == '0)));
endmodule

bind pwm_dual_timer pwm_dual_timer_chk #(.CW(CW)) u_chk (.*);

// File: tb/tb_pwm_dual_timer.sv
`timescale 1ns/1ps
module tb_pwm_dual_timer;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwm_en = 1'b0;
  logic          start_all = 1'b0;
  logic [CW-1:0] period_load = '0;
  logic [CW-1:0] high_load = '0;
  logic [1:0]    mode_down = '0, mode_reload = '0, mode_capture = '0, mode_gen = '0;
  logic [CW-1:0] cnt_period, cnt_high;
  logic          pwm_out;

  int total = 0, bad = 0;
  bit checking = 0, done = 0;
  string tag = "R1";

  // Reference model state
  bit mrun = 0;
  int k = 0, pm = 0, hm = 0, exp_c0 = 0;
  bit exp_pwm = 0;

  always #2 clk = ~clk;

  pwm_dual_timer #(.CW(CW)) dut (.*);

  function automatic bit cfg_ok_tb();
    return (mode_down == 2'b11) && (mode_reload == 2'b11) &&
           (mode_capture == 2'b00) && (mode_gen == 2'b11);
  endfunction

  task automatic chk(string t, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mrun = 0; k = 0; exp_pwm = 0; exp_c0 = 0;
    end else if (!(pwm_en && cfg_ok_tb())) begin
      mrun = 0; exp_pwm = 0;
    end else if (start_all) begin
      mrun = 1; k = 0; pm = int'(period_load); hm = int'(high_load);
      exp_pwm = 1; exp_c0 = pm;
    end else if (mrun) begin
      k++;
      if (k == pm + 2) begin
        k = 0; pm = int'(period_load); hm = int'(high_load);
        exp_pwm = 1; exp_c0 = pm;
      end else begin
        exp_c0 = (k <= pm) ? pm - k : 0;
        if (k == hm + 2) exp_pwm = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      chk(tag, int'(pwm_out), int'(exp_pwm), "pwm_out vs model");
      chk(tag, int'(cnt_period), exp_c0, "cnt_period vs model");
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_all = 1'b1;
    @(negedge clk);
    start_all = 1'b0;
  endtask

  // Measure three periods: high time and full period in cycles
  task automatic measure(int p, int h, string t);
    bit last, seen_low;
    int hi, tot, guard;
    last = pwm_out;
    guard = 0;
    while (!(pwm_out && !last) && guard < 2000) begin
      last = pwm_out;
      @(negedge clk);
      guard++;
    end
    for (int i = 0; i < 3; i++) begin
      hi = 0; tot = 0; seen_low = 0; guard = 0;
      do begin
        tot++;
        if (!pwm_out) seen_low = 1;
        else if (!seen_low) hi++;
        @(negedge clk);
        guard++;
      end while (!(pwm_out && seen_low) && guard < 2000);
      chk(t, tot, p + 2, "measured period");
      chk(t, hi, h + 2, "measured high time");
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(4);
    chk("R1", int'(pwm_out), 0, "pwm_out in reset");
    chk("R1", int'(cnt_period), 0, "cnt_period in reset");
    rst_n = 1'b1;
    checking = 1;
    cyc(3);
    chk("R1", int'(pwm_out), 0, "pwm_out after reset");

    mode_down = 2'b11; mode_reload = 2'b11; mode_capture = 2'b00; mode_gen = 2'b11;
    period_load = 10; high_load = 3;

    tag = "R10";
    pulse_start();
    cyc(5);
    chk("R10", int'(pwm_out), 0, "start without enable");
    chk("R10", int'(cnt_period), 0, "counter untouched");

    tag = "R2";
    pwm_en = 1'b1;
    pulse_start();
    chk("R2", int'(pwm_out), 1, "high right after start");
    chk("R2", int'(cnt_period), 10, "period counter loaded");
    tag = "R3_R4";
    measure(10, 3, "R3_R4");

    tag = "R9";
    cyc(4);
    period_load = 6; high_load = 4;
    measure(6, 4, "R9");

    tag = "R5";
    period_load = 5; high_load = 8;
    cyc(20);
    for (int i = 0; i < 21; i++) begin
      chk("R5", int'(pwm_out), 1, "long high stays high");
      @(negedge clk);
    end
    period_load = 7; high_load = 7;
    cyc(20);
    for (int i = 0; i < 27; i++) begin
      chk("R5", int'(pwm_out), 1, "equal high stays high");
      @(negedge clk);
    end

    tag = "R6";
    period_load = 9; high_load = 2;
    cyc(30);
    pwm_en = 1'b0;
    begin
      int held;
      @(negedge clk);
      chk("R6", int'(pwm_out), 0, "low after disable");
      held = int'(cnt_period);
      cyc(6);
      chk("R6", int'(cnt_period), held, "counter frozen");
      chk("R6", int'(pwm_out), 0, "still low");
    end

    tag = "R8";
    pwm_en = 1'b1;
    pulse_start();
    chk("R8", int'(pwm_out), 1, "restart high");
    measure(9, 2, "R8");

    tag = "R4";
    period_load = 4; high_load = 0;
    measure(4, 0, "R4");

    tag = "R7";
    for (int f = 0; f < 4; f++) begin
      for (int b = 0; b < 2; b++) begin
        pwm_en = 1'b0;
        @(negedge clk);
        case (f)
          0: mode_down[b] = 1'b0;
          1: mode_reload[b] = 1'b0;
          2: mode_capture[b] = 1'b1;
          default: mode_gen[b] = 1'b0;
        endcase
        pwm_en = 1'b1;
        pulse_start();
        cyc(3);
        chk("R7", int'(pwm_out), 0, "bad mode blocks start");
        mode_down = 2'b11; mode_reload = 2'b11; mode_capture = 2'b00; mode_gen = 2'b11;
        @(negedge clk);
      end
    end
    pulse_start();
    chk("R7", int'(pwm_out), 1, "valid mode starts again");
    cyc(10);

    checking = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule